// File: doc/BRIEF.md
# Configuration-Load Link Sequencer

This block is the host-side controller that walks a device through loading a configuration image over a register path in configuration space. It reaches the device only through a simple request/acknowledge register port. Each step is a read, a write, or a read-modify-write of a 32-bit register. In order, the sequencer checks that the device allows this kind of load, switches the device's clocking, flushes the device's internal state machine with runs of dummy data words, and requests configuration. It then waits for the device to report that it is ready, arms the transfer, and programs the clock-to-data ratio that suits the image.

At that point the sequencer raises `stream_go` and hands the register path to an external streaming stage. When that stage pulses `stream_done`, the sequencer takes the path back. It releases the transfer and configuration requests, flushes again, and checks that the ready indication drops. It then looks for a latched configuration error, returns the clocking to normal, and waits for the device to report user clock and user mode. Every failing step latches its own error code. Timeouts are counted as a number of status re-reads, spaced by a cycle interval that is derived from a clock-rate parameter.

Top module: `cfgseq_top`

## Requirements
- R1: After reset, and while idle, `busy`, `bus_req`, `stream_go`, `seq_done`, `seq_fail` and `seq_timeout` are 0. `seq_done` and `seq_fail` are never 1 together.
- R2: The first bus access reads status at 0x21C. If the enable bit (bit 20) is 0, the sequence stops with `seq_fail`=1 and `err_code`=1, and no register write is issued.
- R3: The clock-select bit (bit 1 of mode control at 0x220) is set by one write while the mode-select bit (bit 0) is still 0. Bit 0 is set only by a later, separate write.
- R4: Each flush first writes the clocks-per-word field (mode control bits 15:8) to 1. It then issues exactly FLUSH_WRITES (default 244) writes of zero to the data register at 0x228. A run with no initial teardown contains three flushes.
- R5: When `stream_go` rises, mode control bits 15:8 hold 8 if `img_compressed` is set, 4 if only `img_encrypted` is set, and 1 otherwise. Start-transfer (bit 1 of program control at 0x22C) is already 1 at that moment. No bus request is made while `stream_go` is high.
- R6: After the configuration request (bit 0 of 0x22C) is set, status bit 18 is polled for 1, with at most ceil(RDY_TO_US/POLL_US) reads. If every read misses, the sequence fails with `err_code`=3 and `seq_timeout`=1.
- R7: If status bit 18 is already 1 at start, a full teardown runs before the clock-select write, which gives four flushes in total. If bit 18 then fails to clear, the sequence fails with `err_code`=2.
- R8: Teardown writes program control twice. The first write clears start-transfer while the configuration request is still 1. The second write clears the configuration request.
- R9: After teardown, bit 5 of the latched error register at 0x234 is read. If it is 1, the sequence fails with `err_code`=4.
- R10: Completion clears mode-control bits 0 and 1 in one write. It then polls until status bits 24 and 21 are both 1, which sets `seq_done`. If they are still not both set after ceil(USER_TO_US/POLL_US) reads, the sequence fails with `err_code`=5 and `seq_timeout`=1.
- R11: If status bit 18 stays 1 after the final teardown, the sequence fails with `err_code`=6.
- R12: A `start` pulse while `busy` is 1 is ignored. The running sequence completes once, with its normal access count.
- R13: Once `bus_req` is raised, it stays high with stable address, direction and write data until the cycle in which `bus_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| img_compressed | input | 1 | Image flag, sampled on start |
| img_encrypted | input | 1 | Image flag, sampled on start |
| stream_go | output | 1 | Streaming stage owns the data path |
| stream_done | input | 1 | Streaming stage finished (pulse) |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Configuration-space byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence ended successfully (held) |
| seq_fail | output | 1 | Sequence ended with error (held) |
| seq_timeout | output | 1 | Failure was a poll timeout (held) |
| err_code | output | 3 | Failing step code, 0 when none |

## Verification
The hardest states to reach are the ones where the device misbehaves in the middle of a run. Examples are a ready bit that rises on request but never falls at the final teardown, and a user-mode report that never arrives, so the long poll must run to its read limit. The bench's register responder has behaviour switches for these cases: ready follows the request bit, ready is stuck high, ready rises but never falls, the latched error is set, and user mode is withheld. Each failing run is checked for its code and its exact count of status reads and data writes. Random image flags are mixed with these directed cases.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_STAT = 12'h21C;
  localparam logic [ADDR_W-1:0] A_MODE = 12'h220;
  localparam logic [ADDR_W-1:0] A_DATA = 12'h228;
  localparam logic [ADDR_W-1:0] A_PROG = 12'h22C;
  localparam logic [ADDR_W-1:0] A_LERR = 12'h234;

  localparam int ST_RDY  = 18;
  localparam int ST_EN   = 20;
  localparam int ST_USER = 21;
  localparam int ST_UCLK = 24;
  localparam int MD_SEL  = 0;
  localparam int MD_CLK  = 1;
  localparam int MD_RLSB = 8;
  localparam int PG_CFG  = 0;
  localparam int PG_XFER = 1;
  localparam int LE_BIT  = 5;

  typedef enum logic [1:0] {OP_RD, OP_RMW, OP_WR} bus_op_t;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_NO_EN = 3'd1, E_PRE_TD = 3'd2, E_RDY_TO = 3'd3,
    E_LATCH = 3'd4, E_USER_TO = 3'd5, E_END_TD = 3'd6
  } err_t;

  function automatic logic [7:0] ratio_sel(input logic comp, input logic enc);
    if (comp)     return 8'd8;
    else if (enc) return 8'd4;
    else          return 8'd1;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] rd,
                                              input logic [DATA_W-1:0] clr,
                                              input logic [DATA_W-1:0] set);
    return (rd & ~clr) | set;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/cfgseq_bus.sv
module cfgseq_bus import cfgseq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  bus_op_t           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] clr,
  input  logic [DATA_W-1:0] set,
  output logic              done,
  output logic [DATA_W-1:0] rdat,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  typedef enum logic [1:0] {B_IDLE, B_RD, B_WR} bst_t;
  bst_t bst;
  bus_op_t op_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] clr_q, set_q, wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst <= B_IDLE; op_q <= OP_RD; a_q <= '0; clr_q <= '0; set_q <= '0;
      wd_q <= '0; rdat <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (bst)
        B_IDLE: if (go) begin
          op_q <= op; a_q <= addr; clr_q <= clr; set_q <= set;
          if (op == OP_WR) begin wd_q <= set; bst <= B_WR; end
          else bst <= B_RD;
        end
        B_RD: if (bus_ack) begin
          rdat <= bus_rdata;
          if (op_q == OP_RMW) begin
            wd_q <= merge(bus_rdata, clr_q, set_q);
            bst <= B_WR;
          end else begin
            done <= 1'b1; bst <= B_IDLE;
          end
        end
        B_WR: if (bus_ack) begin done <= 1'b1; bst <= B_IDLE; end
        default: bst <= B_IDLE;
      endcase
    end
  end

  assign bus_req   = (bst != B_IDLE);
  assign bus_we    = (bst == B_WR);
  assign bus_addr  = a_q;
  assign bus_wdata = wd_q;
endmodule

// File: rtl/cfgseq_count.sv
module cfgseq_count #(parameter int W = 8) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) val <= '0;
    else if (inc)      val <= val + W'(1);
  end
endmodule

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(parameter int W = 8, parameter int LEN = 10) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= W'(LEN);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end
  assign expired = (cnt == '0);
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top import cfgseq_pkg::*; #(
  parameter int TICKS_PER_US = 100,
  parameter int POLL_US      = 10,
  parameter int RDY_TO_US    = 10,
  parameter int USER_TO_US   = 2000,
  parameter int FLUSH_WRITES = 244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              img_compressed,
  input  logic              img_encrypted,
  output logic              stream_go,
  input  logic              stream_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              seq_done,
  output logic              seq_fail,
  output logic              seq_timeout,
  output logic [2:0]        err_code
);
  localparam int POLL_CYC   = POLL_US * TICKS_PER_US;
  localparam int RDY_READS  = ceil_div(RDY_TO_US, POLL_US);
  localparam int USER_READS = ceil_div(USER_TO_US, POLL_US);
  localparam int RD_W = $clog2(USER_READS + RDY_READS + 1);
  localparam int FL_W = $clog2(FLUSH_WRITES + 1);
  localparam int TK_W = $clog2(POLL_CYC + 1);
  localparam logic [DATA_W-1:0] RATIO_MASK = 32'h0000_FF00;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_CLKSEL, S_MODESEL, S_CFGREQ, S_XFER, S_RATIO, S_STREAM,
    S_TDX, S_TDC, S_CPL_LERR, S_CPL_MODE, S_FL_CLK, S_FL_WR, S_POLL,
    S_POLL_WAIT, S_DONE, S_FAIL
  } st_t;

  st_t st, fl_ret, poll_ret;
  logic pend, pre_td;
  logic [DATA_W-1:0] p_mask, p_val;
  logic [RD_W-1:0] p_lim;
  err_t p_err, err_q;
  logic [7:0] ratio_q;

  logic need, cmd_go, cmd_done;
  bus_op_t cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_clr, cmd_set, cmd_rd;
  logic [FL_W-1:0] fl_cnt;
  logic [RD_W-1:0] rd_cnt;
  logic tick_exp;

  // named internal events
  logic ev_start, ev_poll_hit, ev_poll_miss, ev_poll_exhaust, ev_flush_word, ev_flush_last;
  assign ev_start        = start && !busy;
  assign ev_poll_hit     = cmd_done && (st == S_POLL) && ((cmd_rd & p_mask) == p_val);
  assign ev_poll_miss    = cmd_done && (st == S_POLL) && ((cmd_rd & p_mask) != p_val);
  assign ev_poll_exhaust = ev_poll_miss && ((rd_cnt + RD_W'(1)) >= p_lim);
  assign ev_flush_word   = cmd_done && (st == S_FL_WR);
  assign ev_flush_last   = ev_flush_word && (fl_cnt == FL_W'(FLUSH_WRITES - 1));

  always_comb begin
    need = 1'b1; cmd_op = OP_RMW; cmd_addr = A_MODE; cmd_clr = '0; cmd_set = '0;
    case (st)
      S_CHK:      begin cmd_op = OP_RD; cmd_addr = A_STAT; end
      S_CLKSEL:   cmd_set = 32'(1) << MD_CLK;
      S_MODESEL:  cmd_set = 32'(1) << MD_SEL;
      S_CFGREQ:   begin cmd_addr = A_PROG; cmd_set = 32'(1) << PG_CFG; end
      S_XFER:     begin cmd_addr = A_PROG; cmd_set = 32'(1) << PG_XFER; end
      S_RATIO:    begin cmd_clr = RATIO_MASK; cmd_set = 32'(ratio_q) << MD_RLSB; end
      S_TDX:      begin cmd_addr = A_PROG; cmd_clr = 32'(1) << PG_XFER; end
      S_TDC:      begin cmd_addr = A_PROG; cmd_clr = 32'(1) << PG_CFG; end
      S_CPL_LERR: begin cmd_op = OP_RD; cmd_addr = A_LERR; end
      S_CPL_MODE: cmd_clr = (32'(1) << MD_SEL) | (32'(1) << MD_CLK);
      S_FL_CLK:   begin cmd_clr = RATIO_MASK; cmd_set = 32'(1) << MD_RLSB; end
      S_FL_WR:    begin cmd_op = OP_WR; cmd_addr = A_DATA; end
      S_POLL:     begin cmd_op = OP_RD; cmd_addr = A_STAT; end
      default:    need = 1'b0;
    endcase
  end
  assign cmd_go = need && !pend;

  cfgseq_bus u_bus (
    .clk, .rst_n, .go(cmd_go), .op(cmd_op), .addr(cmd_addr), .clr(cmd_clr),
    .set(cmd_set), .done(cmd_done), .rdat(cmd_rd), .bus_req, .bus_we,
    .bus_addr, .bus_wdata, .bus_ack, .bus_rdata
  );

  cfgseq_count #(.W(FL_W)) u_flcnt (
    .clk, .rst_n, .clr(st == S_FL_CLK), .inc(ev_flush_word), .val(fl_cnt)
  );

  cfgseq_count #(.W(RD_W)) u_rdcnt (
    .clk, .rst_n, .clr(!(st == S_POLL || st == S_POLL_WAIT)), .inc(ev_poll_miss),
    .val(rd_cnt)
  );

  cfgseq_tick #(.W(TK_W), .LEN(POLL_CYC)) u_tick (
    .clk, .rst_n, .load(ev_poll_miss && !ev_poll_exhaust), .expired(tick_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fl_ret <= S_IDLE; poll_ret <= S_IDLE; pend <= 1'b0;
      pre_td <= 1'b0; p_mask <= '0; p_val <= '0; p_lim <= '0; p_err <= E_NONE;
      err_q <= E_NONE; ratio_q <= 8'd1; seq_done <= 1'b0; seq_fail <= 1'b0;
      seq_timeout <= 1'b0;
    end else begin
      if (cmd_go)   pend <= 1'b1;
      if (cmd_done) pend <= 1'b0;
      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          seq_done <= 1'b0; seq_fail <= 1'b0; seq_timeout <= 1'b0; err_q <= E_NONE;
          ratio_q <= ratio_sel(img_compressed, img_encrypted);
          pre_td <= 1'b0; st <= S_CHK;
        end
        S_CHK: if (cmd_done) begin
          if (!cmd_rd[ST_EN]) begin st <= S_FAIL; seq_fail <= 1'b1; err_q <= E_NO_EN; end
          else if (cmd_rd[ST_RDY]) begin pre_td <= 1'b1; st <= S_TDX; end
          else st <= S_CLKSEL;
        end
        S_CLKSEL:  if (cmd_done) st <= S_MODESEL;
        S_MODESEL: if (cmd_done) begin fl_ret <= S_CFGREQ; st <= S_FL_CLK; end
        S_CFGREQ: if (cmd_done) begin
          p_mask <= 32'(1) << ST_RDY; p_val <= 32'(1) << ST_RDY;
          p_lim <= RD_W'(RDY_READS); p_err <= E_RDY_TO;
          poll_ret <= S_FL_CLK; fl_ret <= S_XFER; st <= S_POLL;
        end
        S_XFER:   if (cmd_done) st <= S_RATIO;
        S_RATIO:  if (cmd_done) st <= S_STREAM;
        S_STREAM: if (stream_done) st <= S_TDX;
        S_TDX:    if (cmd_done) st <= S_TDC;
        S_TDC: if (cmd_done) begin
          p_mask <= 32'(1) << ST_RDY; p_val <= '0; p_lim <= RD_W'(RDY_READS);
          p_err <= pre_td ? E_PRE_TD : E_END_TD;
          poll_ret <= pre_td ? S_CLKSEL : S_CPL_LERR;
          fl_ret <= S_POLL; st <= S_FL_CLK;
        end
        S_CPL_LERR: if (cmd_done) begin
          if (cmd_rd[LE_BIT]) begin st <= S_FAIL; seq_fail <= 1'b1; err_q <= E_LATCH; end
          else st <= S_CPL_MODE;
        end
        S_CPL_MODE: if (cmd_done) begin
          p_mask <= (32'(1) << ST_UCLK) | (32'(1) << ST_USER);
          p_val  <= (32'(1) << ST_UCLK) | (32'(1) << ST_USER);
          p_lim <= RD_W'(USER_READS); p_err <= E_USER_TO;
          poll_ret <= S_DONE; st <= S_POLL;
        end
        S_FL_CLK: if (cmd_done) st <= S_FL_WR;
        S_FL_WR:  if (ev_flush_last) begin
          st <= fl_ret;
          if (fl_ret == S_POLL) pre_td <= pre_td;
        end
        S_POLL: begin
          if (ev_poll_hit) begin
            st <= poll_ret;
            if (poll_ret == S_DONE) seq_done <= 1'b1;
            if (poll_ret == S_CLKSEL) pre_td <= 1'b0;
          end else if (ev_poll_exhaust) begin
            st <= S_FAIL; seq_fail <= 1'b1; seq_timeout <= 1'b1; err_q <= p_err;
          end else if (ev_poll_miss) st <= S_POLL_WAIT;
        end
        S_POLL_WAIT: if (tick_exp) st <= S_POLL;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = !(st == S_IDLE || st == S_DONE || st == S_FAIL);
  assign stream_go = (st == S_STREAM);
  assign err_code  = err_q;
endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk import cfgseq_pkg::*; #(parameter int FLUSH_WRITES = 244) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stream_go,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              seq_done,
  input logic              seq_fail,
  input logic              seq_timeout,
  input logic [2:0]        err_code,
  input logic              ev_flush_word
);
  localparam int CW = $clog2(FLUSH_WRITES + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else if (bus_req && bus_we && bus_ack && bus_addr != A_DATA) run_cnt <= '0;
    else if (ev_flush_word && run_cnt <= CW'(FLUSH_WRITES)) run_cnt <= run_cnt + CW'(1);
  end

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  a_r1_end_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_fail));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !stream_go));
  a_r6_tmo_is_fail: assert property (@(posedge clk) disable iff (!rst_n)
    seq_timeout |-> (seq_fail && err_code != 3'd0));
  a_r5_stream_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stream_go |-> !bus_req);
  a_r4_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(FLUSH_WRITES));
endmodule

bind cfgseq_top cfgseq_chk #(.FLUSH_WRITES(FLUSH_WRITES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stream_go(stream_go), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .seq_done(seq_done), .seq_fail(seq_fail), .seq_timeout(seq_timeout),
  .err_code(err_code), .ev_flush_word(ev_flush_word)
);

// File: tb/tb_cfgseq_top.sv
module tb_cfgseq_top;
  localparam int TPU = 2, POLL_US = 10, RDY_TO = 10, USER_TO = 2000, FLUSH = 244;
  localparam int RDY_N = (RDY_TO + POLL_US - 1) / POLL_US;
  localparam int USER_N = (USER_TO + POLL_US - 1) / POLL_US;

  logic clk = 0, rst_n = 0, start = 0, comp = 0, enc = 0, stream_done = 0;
  logic stream_go, bus_req, bus_we, busy, seq_done, seq_fail, seq_timeout;
  logic [11:0] bus_addr; logic [31:0] bus_wdata; logic [2:0] err_code;
  logic bus_ack = 0; logic [31:0] bus_rdata = 0;

  always #5 clk = ~clk;

  cfgseq_top #(.TICKS_PER_US(TPU), .POLL_US(POLL_US), .RDY_TO_US(RDY_TO),
               .USER_TO_US(USER_TO), .FLUSH_WRITES(FLUSH)) dut (
    .clk, .rst_n, .start, .img_compressed(comp), .img_encrypted(enc), .stream_go,
    .stream_done, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .busy, .seq_done, .seq_fail, .seq_timeout, .err_code);

  // device model knobs and observations
  bit k_en, k_rdy, k_follow, k_nofall, k_lerr, k_uok;
  logic [31:0] m_mode, m_prog;
  int wr_cnt, data_wr, stat_rd, bad_flush, hold_err, td_idx;
  bit ran, sg_q, clk_seen, clk_ok, sel_later, pend_q;
  logic [31:0] td_w0, td_w1, last_mode, sg_mode, sg_prog;
  logic [11:0] a_q; logic we_q; logic [31:0] d_q;
  int checks = 0, fails = 0;

  function automatic logic [31:0] stat_val();
    logic [31:0] v = 0;
    v[20] = k_en; v[18] = k_rdy;
    if (k_uok && ran && m_mode[1:0] == 2'b00) begin v[24] = 1; v[21] = 1; end
    return v;
  endfunction

  always @(posedge clk) begin
    if (pend_q && (!bus_req || bus_addr != a_q || bus_we != we_q || bus_wdata != d_q)) hold_err++;
    pend_q = bus_req && !bus_ack; a_q = bus_addr; we_q = bus_we; d_q = bus_wdata;
    if (stream_go && !sg_q) begin sg_mode = m_mode; sg_prog = m_prog; ran = 1; end
    sg_q = stream_go;
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wr_cnt++;
        case (bus_addr)
          12'h220: begin
            if (!clk_seen && bus_wdata[1]) begin clk_seen = 1; clk_ok = !bus_wdata[0]; end
            else if (clk_seen && bus_wdata[0] && !m_mode[0]) sel_later = 1;
            m_mode = bus_wdata; last_mode = bus_wdata;
          end
          12'h228: begin data_wr++; if (m_mode[15:8] != 8'd1 || bus_wdata != 0) bad_flush++; end
          12'h22C: begin
            if (ran) begin if (td_idx == 0) td_w0 = bus_wdata; if (td_idx == 1) td_w1 = bus_wdata; td_idx++; end
            if (bus_wdata[0]) begin if (k_follow) k_rdy = 1; end
            else if (k_follow && !k_nofall) k_rdy = 0;
            m_prog = bus_wdata;
          end
          default: ;
        endcase
      end else begin
        case (bus_addr)
          12'h21C: begin stat_rd++; bus_rdata <= stat_val(); end
          12'h220: bus_rdata <= m_mode;
          12'h22C: bus_rdata <= m_prog;
          12'h234: bus_rdata <= k_lerr ? 32'h20 : 32'h0;
          default: bus_rdata <= 32'h0;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  function automatic int exp_ratio(input bit c, input bit e);
    case ({c, e})
      2'b10, 2'b11: return 8;
      2'b01:        return 4;
      default:      return 1;
    endcase
  endfunction

  task automatic run(input bit c, e, en, rdy0, fol, nof, le, uok, poke);
    int sgc = 0;
    k_en = en; k_rdy = rdy0; k_follow = fol; k_nofall = nof; k_lerr = le; k_uok = uok;
    m_mode = 0; m_prog = 0; wr_cnt = 0; data_wr = 0; stat_rd = 0; bad_flush = 0;
    td_idx = 0; ran = 0; clk_seen = 0; clk_ok = 0; sel_later = 0;
    td_w0 = 0; td_w1 = 0; last_mode = 0; sg_mode = 0; sg_prog = 0;
    @(negedge clk); comp = c; enc = e; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (poke) start = (i == 50);
      if (stream_go) sgc++;
      stream_done = (sgc == 3);
      if (!busy) break;
    end
    start = 0; stream_done = 0;
    chk(!busy, "watchdog", busy, 0);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !stream_go && !seq_done && !seq_fail && !seq_timeout,
        "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_req, "R1 idle", bus_req, 0);

    for (int n = 0; n < 5; n++) begin
      bit c = $urandom() % 2, e = $urandom() % 2;
      run(c, e, 1, 0, 1, 0, 0, 1, n == 2);
      chk(seq_done && !seq_fail, "R10 done", err_code, 0);
      chk(!(seq_done && seq_fail), "R1 excl", seq_fail, 0);
      chk(clk_seen && clk_ok && sel_later, "R3 order", clk_ok, 1);
      chk(data_wr == 3 * FLUSH && bad_flush == 0, "R4 flush", data_wr, 3 * FLUSH);
      chk(int'(sg_mode[15:8]) == exp_ratio(c, e), "R5 ratio", sg_mode[15:8], exp_ratio(c, e));
      chk(sg_prog[1] == 1, "R5 xfer armed", sg_prog[1], 1);
      chk(td_w0[1:0] == 2'b01 && td_w1[1:0] == 2'b00, "R8 teardown", td_w0[1:0], 1);
      chk(last_mode[1:0] == 2'b00, "R10 mode clear", last_mode[1:0], 0);
      chk(stat_rd == 4, "R6 ready one read", stat_rd, 4);
      if (n == 2) chk(wr_cnt == 3 * (FLUSH + 1) + 8, "R12 start ignored", wr_cnt, 3 * (FLUSH + 1) + 8);
      chk(hold_err == 0, "R13 hold", hold_err, 0);
    end

    run(1, 1, 1, 0, 1, 0, 0, 1, 0);
    chk(int'(sg_mode[15:8]) == 8, "R5 both flags", sg_mode[15:8], 8);

    run(0, 0, 0, 0, 1, 0, 0, 1, 0);
    chk(seq_fail && err_code == 3'd1 && wr_cnt == 0, "R2 not enabled", err_code, 1);

    run(0, 0, 1, 0, 0, 0, 0, 1, 0);
    chk(seq_fail && seq_timeout && err_code == 3'd3, "R6 ready timeout", err_code, 3);
    chk(stat_rd == 1 + RDY_N && data_wr == FLUSH, "R6 read count", stat_rd, 1 + RDY_N);

    run(0, 1, 1, 1, 1, 0, 0, 1, 0);
    chk(seq_done && data_wr == 4 * FLUSH, "R7 pre-teardown", data_wr, 4 * FLUSH);

    run(0, 0, 1, 1, 0, 0, 0, 1, 0);
    chk(seq_fail && err_code == 3'd2 && !clk_seen, "R7 stuck ready", err_code, 2);

    run(0, 0, 1, 0, 1, 0, 1, 1, 0);
    chk(seq_fail && !seq_timeout && err_code == 3'd4, "R9 latched error", err_code, 4);

    run(0, 0, 1, 0, 1, 1, 0, 1, 0);
    chk(seq_fail && seq_timeout && err_code == 3'd6, "R11 end teardown", err_code, 6);

    run(0, 0, 1, 0, 1, 0, 0, 0, 0);
    chk(seq_fail && seq_timeout && err_code == 3'd5, "R10 user timeout", err_code, 5);
    chk(stat_rd == 3 + USER_N, "R10 user reads", stat_rd, 3 + USER_N);
    chk(last_mode[1:0] == 2'b00, "R10 clear before poll", last_mode[1:0], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule